// File: doc/BRIEF.md
# Display Cursor Settings Bank with Grouped Update

This block holds every setting a display pipeline needs to draw a hardware cursor: an on/off control, a pixel format, 2x magnification, an inverse-transparent clamp, screen position, hot-spot offset, size, two 24-bit colours and a 40-bit surface base address. Software reaches the settings over a plain register bus with write and read strobes. Every write goes into a pending copy, and reads return that pending copy.

The display logic sees a second, active copy. The active copy takes the whole pending copy in one step, on a frame-start pulse, and only when software has not set the update lock. Software therefore sets the lock, rewrites any number of fields, and clears the lock. The next frame start then moves the whole group at once, so a frame never shows a half-updated cursor.

The 40-bit base address is split across two registers. Writing the upper byte only stages it. Writing the low word builds the new pending address from the staged byte and the low word. The address is 4 KiB aligned, so its low 12 bits are always zero.

Top module: `cursor_regbank`

## Requirements
- R1: Offset 0 holds the controls: bit 0 is enable, bits 2:1 are the mode, bit 3 is magnify and bit 4 is clamp. A read strobe returns the pending value of the addressed register on `bus_rdata` one cycle later. Unused bits read as zero.
- R2: The mode takes four codes: 0 is monochrome, 1 is colour with a 1-bit AND mask, 2 is colour with premultiplied alpha and 3 is colour with straight alpha. Each code is stored as written and presented unchanged on `cur_mode`.
- R3: Offset 2 holds X in bits 12:0 and Y in bits 28:16. Offset 3 holds hot-spot X in bits 5:0 and hot-spot Y in bits 13:8.
- R4: Offset 4 holds width minus one in bits 6:0 and height minus one in bits 14:8. These values are presented as stored, so 0 means a size of one pixel.
- R5: Offsets 5 and 6 hold colour A and colour B, each laid out as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R6: Offset 7 bits 7:0 stage address bits 39:32, and a read of offset 7 returns the staged byte. Writing offset 7 alone changes neither the pending address nor `cur_base`.
- R7: A write to offset 8 sets the pending address to {staged byte, written bits 31:12}. Written bits 11:0 are ignored. Offset 8 reads back with bits 11:0 zero, and `cur_base` bits 11:0 are always zero.
- R8: Offset 1 bit 0 is the update lock. While it is set, frame-start pulses leave every active output unchanged.
- R9: The active outputs change only on a frame start while the lock is clear. The lock is taken as held before that clock edge. On such a frame start the outputs take the pending copy held before the same edge, and they show it one cycle after the pulse. Writes without a frame start do not change the outputs.
- R10: After reset, the lock is clear and every setting is zero, except that colour B is FFFFFF. This gives black and white for monochrome use.
- R11: Offsets 9 to 15 read as zero, and writes to them change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cur_enable | output | 1 | Active enable |
| cur_mode | output | 2 | Active pixel format code |
| cur_magnify | output | 1 | Active 2x magnify |
| cur_clamp | output | 1 | Active inverse-transparent clamp |
| cur_x | output | 13 | Active X position |
| cur_y | output | 13 | Active Y position |
| cur_hot_x | output | 6 | Active hot-spot X |
| cur_hot_y | output | 6 | Active hot-spot Y |
| cur_width_m1 | output | 7 | Active width minus one |
| cur_height_m1 | output | 7 | Active height minus one |
| cur_color_a | output | 24 | Active colour A {R,G,B} |
| cur_color_b | output | 24 | Active colour B {R,G,B} |
| cur_base | output | 40 | Active surface base byte address |

## Verification
A write reaches the pending copy at the first rising edge, so a read strobe raised at the following falling edge sees it. The read data then appears at the next rising edge. The active outputs move at the rising edge that samples `frame_start`. The bench drives every strobe on a falling edge, drops it on the next falling edge, and samples results at that point, so each check comes exactly one edge after its cause. The case where a write and a frame start share a cycle is checked to show the old pending value. The new value must then appear only after the following frame start.

// File: rtl/cursor_regbank_pkg.sv
package cursor_regbank_pkg;

    // bus geometry
    parameter int BUS_AW    = 4;
    parameter int BUS_DW    = 32;

    // field widths
    parameter int COORD_W   = 13;
    parameter int HOT_W     = 6;
    parameter int SIZE_W    = 7;
    parameter int CHAN_W    = 8;
    parameter int BASE_W    = 40;
    parameter int PAGE_BITS = 12;

    // upper-half field positions inside a bus word
    parameter int POS_HI_LSB  = 16;
    parameter int PAIR_HI_LSB = 8;

    localparam int HI_W   = BASE_W - BUS_DW;
    localparam int LO_W   = BUS_DW - PAGE_BITS;
    localparam int PAGE_W = BASE_W - PAGE_BITS;
    localparam int RGB_W  = 3 * CHAN_W;

    // register offsets
    localparam logic [BUS_AW-1:0] OFS_CTRL    = BUS_AW'(0);
    localparam logic [BUS_AW-1:0] OFS_LOCK    = BUS_AW'(1);
    localparam logic [BUS_AW-1:0] OFS_POS     = BUS_AW'(2);
    localparam logic [BUS_AW-1:0] OFS_HOT     = BUS_AW'(3);
    localparam logic [BUS_AW-1:0] OFS_SIZE    = BUS_AW'(4);
    localparam logic [BUS_AW-1:0] OFS_COL_A   = BUS_AW'(5);
    localparam logic [BUS_AW-1:0] OFS_COL_B   = BUS_AW'(6);
    localparam logic [BUS_AW-1:0] OFS_BASE_HI = BUS_AW'(7);
    localparam logic [BUS_AW-1:0] OFS_BASE_LO = BUS_AW'(8);

    typedef enum logic [1:0] {
        CM_MONO     = 2'd0,
        CM_ANDMASK  = 2'd1,
        CM_PREMUL   = 2'd2,
        CM_STRAIGHT = 2'd3
    } cur_mode_e;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic               enable;
        cur_mode_e          mode;
        logic               magnify;
        logic               clamp;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [HOT_W-1:0]   hot_x;
        logic [HOT_W-1:0]   hot_y;
        logic [SIZE_W-1:0]  wm1;
        logic [SIZE_W-1:0]  hm1;
        rgb_t               col_a;
        rgb_t               col_b;
        logic [PAGE_W-1:0]  page;
    } cur_cfg_t;

    function automatic cur_cfg_t cfg_reset();
        cur_cfg_t c;
        c       = '0;
        c.col_b = '{r: '1, g: '1, b: '1};
        return c;
    endfunction

endpackage

// File: rtl/cursor_pending.sv
module cursor_pending
    import cursor_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    output cur_cfg_t          pend_cfg,
    output logic              lock,
    output logic [HI_W-1:0]   hi_stage
);

    typedef struct packed {
        cur_cfg_t        cfg;
        logic            lock;
        logic [HI_W-1:0] hi;
    } pend_st_t;

    pend_st_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_CTRL: begin
                    st_d.cfg.enable  = wr_data[0];
                    st_d.cfg.mode    = cur_mode_e'(wr_data[2:1]);
                    st_d.cfg.magnify = wr_data[3];
                    st_d.cfg.clamp   = wr_data[4];
                end
                OFS_LOCK: st_d.lock = wr_data[0];
                OFS_POS: begin
                    st_d.cfg.x = wr_data[COORD_W-1:0];
                    st_d.cfg.y = wr_data[POS_HI_LSB +: COORD_W];
                end
                OFS_HOT: begin
                    st_d.cfg.hot_x = wr_data[HOT_W-1:0];
                    st_d.cfg.hot_y = wr_data[PAIR_HI_LSB +: HOT_W];
                end
                OFS_SIZE: begin
                    st_d.cfg.wm1 = wr_data[SIZE_W-1:0];
                    st_d.cfg.hm1 = wr_data[PAIR_HI_LSB +: SIZE_W];
                end
                OFS_COL_A:   st_d.cfg.col_a = wr_data[RGB_W-1:0];
                OFS_COL_B:   st_d.cfg.col_b = wr_data[RGB_W-1:0];
                OFS_BASE_HI: st_d.hi = wr_data[HI_W-1:0];
                // low word completes the address from the staged byte
                OFS_BASE_LO: st_d.cfg.page = {st_q.hi, wr_data[BUS_DW-1:PAGE_BITS]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg  <= cfg_reset();
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_cfg = st_q.cfg;
    assign lock     = st_q.lock;
    assign hi_stage = st_q.hi;

endmodule

// File: rtl/cursor_readback.sv
module cursor_readback
    import cursor_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] rd_addr,
    input  cur_cfg_t          pend_cfg,
    input  logic              lock,
    input  logic [HI_W-1:0]   hi_stage,
    output logic [BUS_DW-1:0] rd_data
);

    logic [BUS_DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = '0;
            case (rd_addr)
                OFS_CTRL: begin
                    rd_d[0]   = pend_cfg.enable;
                    rd_d[2:1] = pend_cfg.mode;
                    rd_d[3]   = pend_cfg.magnify;
                    rd_d[4]   = pend_cfg.clamp;
                end
                OFS_LOCK: rd_d[0] = lock;
                OFS_POS: begin
                    rd_d[COORD_W-1:0]          = pend_cfg.x;
                    rd_d[POS_HI_LSB +: COORD_W] = pend_cfg.y;
                end
                OFS_HOT: begin
                    rd_d[HOT_W-1:0]            = pend_cfg.hot_x;
                    rd_d[PAIR_HI_LSB +: HOT_W] = pend_cfg.hot_y;
                end
                OFS_SIZE: begin
                    rd_d[SIZE_W-1:0]            = pend_cfg.wm1;
                    rd_d[PAIR_HI_LSB +: SIZE_W] = pend_cfg.hm1;
                end
                OFS_COL_A:   rd_d[RGB_W-1:0] = pend_cfg.col_a;
                OFS_COL_B:   rd_d[RGB_W-1:0] = pend_cfg.col_b;
                OFS_BASE_HI: rd_d[HI_W-1:0]  = hi_stage;
                OFS_BASE_LO: rd_d[BUS_DW-1:PAGE_BITS] = pend_cfg.page[LO_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cursor_commit.sv
module cursor_commit
    import cursor_regbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_start,
    input  logic     lock,
    input  cur_cfg_t pend_cfg,
    output cur_cfg_t act_cfg
);

    cur_cfg_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (frame_start && !lock) act_d = pend_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= cfg_reset();
        else        act_q <= act_d;
    end

    assign act_cfg = act_q;

endmodule

// File: rtl/cursor_regbank.sv
module cursor_regbank
    import cursor_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    input  logic               frame_start,
    output logic               cur_enable,
    output logic [1:0]         cur_mode,
    output logic               cur_magnify,
    output logic               cur_clamp,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic [HOT_W-1:0]   cur_hot_x,
    output logic [HOT_W-1:0]   cur_hot_y,
    output logic [SIZE_W-1:0]  cur_width_m1,
    output logic [SIZE_W-1:0]  cur_height_m1,
    output logic [RGB_W-1:0]   cur_color_a,
    output logic [RGB_W-1:0]   cur_color_b,
    output logic [BASE_W-1:0]  cur_base
);

    cur_cfg_t        pend_cfg;
    cur_cfg_t        act_cfg;
    logic            lock_w;
    logic [HI_W-1:0] hi_stage;

    cursor_pending u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .pend_cfg (pend_cfg),
        .lock     (lock_w),
        .hi_stage (hi_stage)
    );

    cursor_readback u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_rd),
        .rd_addr  (bus_addr),
        .pend_cfg (pend_cfg),
        .lock     (lock_w),
        .hi_stage (hi_stage),
        .rd_data  (bus_rdata)
    );

    cursor_commit u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .lock        (lock_w),
        .pend_cfg    (pend_cfg),
        .act_cfg     (act_cfg)
    );

    assign cur_enable    = act_cfg.enable;
    assign cur_mode      = act_cfg.mode;
    assign cur_magnify   = act_cfg.magnify;
    assign cur_clamp     = act_cfg.clamp;
    assign cur_x         = act_cfg.x;
    assign cur_y         = act_cfg.y;
    assign cur_hot_x     = act_cfg.hot_x;
    assign cur_hot_y     = act_cfg.hot_y;
    assign cur_width_m1  = act_cfg.wm1;
    assign cur_height_m1 = act_cfg.hm1;
    assign cur_color_a   = act_cfg.col_a;
    assign cur_color_b   = act_cfg.col_b;
    assign cur_base      = {act_cfg.page, {PAGE_BITS{1'b0}}};

endmodule

// File: rtl/cursor_regbank_chk.sv
module cursor_regbank_chk
    import cursor_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              lock_w,
    input cur_cfg_t          pend_cfg,
    input cur_cfg_t          act_cfg
);

    // R8: a held lock freezes the active copy
    p_lock_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> $stable(act_cfg));

    // R9: no frame start, no change of the active copy
    p_no_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_cfg));

    // R9: an unlocked frame start takes the pending copy
    p_commit_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !lock_w) |=> (act_cfg == $past(pend_cfg)));

    // R6: staging the upper byte leaves the pending address alone
    p_hi_stage_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_BASE_HI) |=> $stable(pend_cfg.page));

endmodule

bind cursor_regbank cursor_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .lock_w      (lock_w),
    .pend_cfg    (pend_cfg),
    .act_cfg     (act_cfg)
);

// File: tb/cursor_regbank_bench.sv
module cursor_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_start = 1'b0;
    logic        cur_enable, cur_magnify, cur_clamp;
    logic [1:0]  cur_mode;
    logic [12:0] cur_x, cur_y;
    logic [5:0]  cur_hot_x, cur_hot_y;
    logic [6:0]  cur_width_m1, cur_height_m1;
    logic [23:0] cur_color_a, cur_color_b;
    logic [39:0] cur_base;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cursor_regbank u_cursor_regbank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_start(frame_start), .cur_enable(cur_enable), .cur_mode(cur_mode),
        .cur_magnify(cur_magnify), .cur_clamp(cur_clamp), .cur_x(cur_x),
        .cur_y(cur_y), .cur_hot_x(cur_hot_x), .cur_hot_y(cur_hot_y),
        .cur_width_m1(cur_width_m1), .cur_height_m1(cur_height_m1),
        .cur_color_a(cur_color_a), .cur_color_b(cur_color_b), .cur_base(cur_base)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [12:0] x1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 enable", cur_enable, 0);
        chk("R10 mode", cur_mode, 0);
        chk("R10 pos", {cur_x, cur_y}, 0);
        chk("R10 size", {cur_width_m1, cur_height_m1}, 0);
        chk("R10 colour A", cur_color_a, 24'h000000);
        chk("R10 colour B", cur_color_b, 24'hFFFFFF);
        chk("R10 base", cur_base, 0);
        rd(4'd1, r); chk("R10 lock clear", r, 0);
        rd(4'd6, r); chk("R10 colour B read", r, 32'h00FF_FFFF);

        // R1 R2 control sweep, upper data bits set to prove they are dropped
        for (int i = 0; i < 32; i++) begin
            wr(4'd0, 32'hFFFF_FFE0 | i);
            rd(4'd0, r); chk("R1 ctrl readback", r, i);
            frame();
            chk("R1 enable out", cur_enable, i & 1);
            chk("R2 mode code", cur_mode, (i >> 1) & 3);
            chk("R1 magnify out", cur_magnify, (i >> 3) & 1);
            chk("R1 clamp out", cur_clamp, (i >> 4) & 1);
        end

        // R4 size sweep, width minus one over its full range
        for (int w = 0; w < 128; w++) begin
            logic [6:0] h;
            h = 7'(127 - w);
            wr(4'd4, {16'hABCD, 1'b1, h, 1'b1, 7'(w)});
            rd(4'd4, r); chk("R4 size readback", r, {17'd0, h, 1'b0, 7'(w)});
            frame();
            chk("R4 width m1", cur_width_m1, w);
            chk("R4 height m1", cur_height_m1, h);
        end

        // R3 position and hot spot
        for (int i = 0; i < 24; i++) begin
            logic [12:0] x, y;
            logic [5:0]  hx, hy;
            x  = 13'((i * 1237 + 5) % 8192);
            y  = 13'((i * 3001 + 77) % 8192);
            hx = 6'((i * 7) % 64);
            hy = 6'(63 - i);
            wr(4'd2, {3'b111, y, 3'b111, x});
            wr(4'd3, {18'h3FFFF, hy, 2'b11, hx});
            rd(4'd2, r); chk("R3 pos readback", r, {3'b0, y, 3'b0, x});
            rd(4'd3, r); chk("R3 hot readback", r, {18'd0, hy, 2'b0, hx});
            frame();
            chk("R3 x", cur_x, x);
            chk("R3 y", cur_y, y);
            chk("R3 hot x", cur_hot_x, hx);
            chk("R3 hot y", cur_hot_y, hy);
        end

        // R5 colours
        for (int i = 0; i < 8; i++) begin
            logic [23:0] ca, cb;
            ca = 24'((i * 24'h10305) ^ 24'h00A5F0);
            cb = ~ca;
            wr(4'd5, {8'hEE, ca});
            wr(4'd6, {8'hEE, cb});
            rd(4'd5, r); chk("R5 colour A readback", r, {8'd0, ca});
            frame();
            chk("R5 colour A", cur_color_a, ca);
            chk("R5 colour B", cur_color_b, cb);
        end

        // R6 R7 split address
        wr(4'd8, 32'h1234_5FFF);
        frame();
        chk("R7 low with zero high", cur_base, 40'h00_1234_5000);
        rd(4'd8, r); chk("R7 low bits read zero", r, 32'h1234_5000);
        wr(4'd7, 32'hFFFF_FFA5);
        rd(4'd7, r); chk("R6 staged byte readback", r, 32'h0000_00A5);
        rd(4'd8, r); chk("R6 low unchanged by high", r, 32'h1234_5000);
        frame();
        chk("R6 high alone no effect", cur_base, 40'h00_1234_5000);
        wr(4'd8, 32'hDEAD_BFFF);
        frame();
        chk("R7 full address", cur_base, 40'hA5_DEAD_B000);
        wr(4'd8, 32'h0000_1ABC);
        frame();
        chk("R7 staged byte reused", cur_base, 40'hA5_0000_1000);

        // R8 lock
        wr(4'd2, 32'h0000_0100);
        frame();
        x1 = 13'h100;
        wr(4'd1, 32'h1);
        rd(4'd1, r); chk("R8 lock readback", r, 1);
        wr(4'd2, 32'h0000_0555);
        wr(4'd0, 32'h0000_0007);
        for (int f = 0; f < 3; f++) begin
            frame();
            chk("R8 locked x held", cur_x, x1);
            chk("R8 locked ctrl held", cur_mode, 2'd0 | (31 >> 1) & 3);
        end
        rd(4'd2, r); chk("R1 pending visible while locked", r, 32'h0000_0555);
        wr(4'd1, 32'h0);
        chk("R9 unlock without frame", cur_x, x1);
        frame();
        chk("R9 commit after unlock", cur_x, 13'h555);
        chk("R9 ctrl grouped commit", cur_mode, 2'd3);

        // R9 write and frame start in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h0000_0AAA; frame_start = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; frame_start = 1'b0;
        chk("R9 same cycle takes old", cur_x, 13'h555);
        frame();
        chk("R9 next frame takes new", cur_x, 13'hAAA);

        // R11 unmapped offsets
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), r); chk("R11 unmapped reads zero", r, 0);
        end
        rd(4'd0, r); chk("R11 ctrl untouched", r, 32'h7);
        rd(4'd1, r); chk("R11 lock untouched", r, 0);
        frame();
        chk("R11 x untouched", cur_x, 13'hAAA);
        chk("R11 base untouched", cur_base, 40'hA5_0000_1000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule